// File: doc/BRIEF.md
# GPIO Register Bank

This block is a memory-mapped controller for a bank of general-purpose pins, 95 by default. It is reached through a plain 32-bit register port: a byte address, a write strobe with write data, and read data that follows the address combinationally. Two kinds of register share the one address space. Bitmapped words pack one bit per pin. Each pin also has a pair of configuration words.

For each pin the bank drives an output level, an output enable and a two-bit weak-pull code to the pad. It samples the pad input through a synchronizer. The synchronized level reaches software and an interrupt unit only while the pin's input sensing is switched on. A read-only ownership bitmap shows which pins firmware keeps for itself; it is loaded from a strap input. A one-bit global control picks which of two system interrupt lines the interrupt unit raises.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset every pin is an input in GPIO mode with sensing off. Its first config word reads 0x00000005, its second reads 0x00000004, pad_oe, pad_out, pad_pull and pin_level are all zero, and irq_sel is 0.
- R2: Ownership word k, at byte offset 4*k for k from 0 to 2, returns strap bit 32*k+j in bit j. Bits above the last pin read 0, and writes to these words leave them unchanged.
- R3: The first config word of pin p is at 0x100+8*p. A write stores bit 31 (output level), bit 2 (direction, 1 = input) and bit 0 (use-select, 1 = GPIO). All other written bits, bit 30 included, are dropped, and pad_out[p] follows the stored bit 31 one cycle after the write.
- R4: pad_oe[p] is 1 exactly when pin p has use-select 1 and direction 0.
- R5: The second config word of pin p is at 0x104+8*p. A write stores bit 2 (sensing off) and bits 1:0 (pull code), drops all other bits, and drives the pull code on pad_pull[2p+1:2p].
- R6: A change on pad_in[p] reaches bit 30 of the pin's first config word and pin_level[p] after the second rising clock edge, and not after the first.
- R7: While sensing is off for a pin, its bit 30 and pin_level read 0. Switching sensing on or off takes effect in the cycle after the config write, with no further synchronizer delay.
- R8: Bit 0 of the global control word at 0x7C reads back and drives irq_sel (0 = line 14, 1 = line 15). All of its other bits read 0.
- R9: Any address outside the ownership words, the control word and the config words of existing pins reads 0, and writing to such an address changes no state. This includes the words past the last pin.
- R10: A config write changes only the addressed pin; every other pin's outputs and read-back stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| owner_strap | input | NUM_PINS | Ownership bits; 0 marks a firmware-reserved pin |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pull | output | 2*NUM_PINS | Weak-pull code per pin, two bits each |
| pin_level | output | NUM_PINS | Gated synchronized input levels for the interrupt unit |
| irq_sel | output | 1 | Interrupt line choice, 1 selects line 15 |

## Verification
The bench sweeps every pin with data patterns derived from the pin number, and sets bits that should be dropped in every write. A decoder that stored junk bits, or that mixed up the direction and output-enable polarity, would fail the read-back or the pad vectors. The pad input is sampled one edge and two edges after a change. A missing synchronizer stage would show the level one cycle early, and an extra stage would show it one cycle late. Sensing is also toggled on a pin whose input is high, to catch a gate that was placed before the synchronizer instead of after it. The words just past the last pin and the unmapped gaps are written with all ones and read back, to catch an index decode that wraps onto pin 94 or onto a real register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned IDX_W = 8;

    localparam logic [31:0] CTL_OFS  = 32'h0000_007C;
    localparam logic [31:0] CFG_BASE = 32'h0000_0100;

    localparam int B_OUT  = 31;
    localparam int B_IN   = 30;
    localparam int B_DIR  = 2;
    localparam int B_USE  = 0;
    localparam int B_SOFF = 2;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_OWN,
        RK_CTL,
        RK_CFG1,
        RK_CFG2
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic out_lvl;
        logic dir_in;
        logic use_gpio;
    } pad_fields_t;

    typedef struct packed {
        logic       sense_off;
        logic [1:0] pull;
    } sense_fields_t;

    localparam pad_fields_t   PAD_RST   = '{out_lvl: 1'b0, dir_in: 1'b1, use_gpio: 1'b1};
    localparam sense_fields_t SENSE_RST = '{sense_off: 1'b1, pull: 2'b00};

    // Map a byte address onto a register kind and an index (word or pin).
    function automatic reg_sel_t decode_addr(input logic [31:0] a, input int unsigned npins);
        logic [31:0]  wa;
        logic [31:0]  pin;
        int unsigned  words;
        reg_sel_t     s;
        wa     = a & ~32'h3;
        words  = (npins + 31) / 32;
        pin    = (wa - CFG_BASE) >> 3;
        s.kind = RK_NONE;
        s.idx  = '0;
        if (wa < 32'(words * 4)) begin
            s.kind = RK_OWN;
            s.idx  = IDX_W'(wa >> 2);
        end else if (wa == CTL_OFS) begin
            s.kind = RK_CTL;
        end else if (wa >= CFG_BASE && pin < 32'(npins)) begin
            s.kind = wa[2] ? RK_CFG2 : RK_CFG1;
            s.idx  = IDX_W'(pin);
        end
        return s;
    endfunction

    function automatic logic [31:0] cfg1_word(input pad_fields_t p, input logic lvl);
        logic [31:0] w;
        w        = '0;
        w[B_OUT] = p.out_lvl;
        w[B_IN]  = lvl;
        w[B_DIR] = p.dir_in;
        w[B_USE] = p.use_gpio;
        return w;
    endfunction

    function automatic logic [31:0] cfg2_word(input sense_fields_t s);
        logic [31:0] w;
        w         = '0;
        w[B_SOFF] = s.sense_off;
        w[1:0]    = s.pull;
        return w;
    endfunction

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_bank_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_pad_en,
    input  logic          wr_sense_en,
    input  pad_fields_t   pad_nxt,
    input  sense_fields_t sense_nxt,
    input  logic          pad_i,
    output pad_fields_t   pad_q,
    output sense_fields_t sense_q,
    output logic          level_o
);

    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_q   <= PAD_RST;
            sense_q <= SENSE_RST;
            sync_q  <= '0;
        end else begin
            if (wr_pad_en)   pad_q   <= pad_nxt;
            if (wr_sense_en) sense_q <= sense_nxt;
            sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
        end
    end

    // Gate after the synchronizer, so sensing on/off acts at once.
    assign level_o = sync_q[SYNC_STAGES-1] & ~sense_q.sense_off;

endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 95,
    parameter int unsigned WORDS    = 3
) (
    input  reg_sel_t                       sel,
    input  logic          [WORDS-1:0][31:0] own_words,
    input  pad_fields_t   [NUM_PINS-1:0]   pad_q,
    input  sense_fields_t [NUM_PINS-1:0]   sense_q,
    input  logic          [NUM_PINS-1:0]   level,
    input  logic                           irq_sel,
    output logic          [31:0]           rdata
);

    always_comb begin
        rdata = '0;
        case (sel.kind)
            RK_OWN: begin
                for (int w = 0; w < int'(WORDS); w++) begin
                    if (sel.idx == IDX_W'(w)) rdata = own_words[w];
                end
            end
            RK_CTL: rdata = {31'b0, irq_sel};
            RK_CFG1: begin
                for (int p = 0; p < int'(NUM_PINS); p++) begin
                    if (sel.idx == IDX_W'(p)) rdata = cfg1_word(pad_q[p], level[p]);
                end
            end
            RK_CFG2: begin
                for (int p = 0; p < int'(NUM_PINS); p++) begin
                    if (sel.idx == IDX_W'(p)) rdata = cfg2_word(sense_q[p]);
                end
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 95,
    parameter int unsigned ADDR_W   = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   owner_strap,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [2*NUM_PINS-1:0] pad_pull,
    output logic [NUM_PINS-1:0]   pin_level,
    output logic                  irq_sel
);

    localparam int unsigned WORDS    = (NUM_PINS + 31) / 32;
    localparam int unsigned OWN_BITS = WORDS * 32;

    reg_sel_t                      sel;
    pad_fields_t                   wr_pad;
    sense_fields_t                 wr_sense;
    pad_fields_t   [NUM_PINS-1:0]  pad_q;
    sense_fields_t [NUM_PINS-1:0]  sense_q;
    logic          [WORDS-1:0][31:0] own_words;
    logic                          unused_wbits;

    assign sel       = decode_addr(32'(bus_addr), NUM_PINS);
    assign own_words = OWN_BITS'(owner_strap);

    assign wr_pad   = '{out_lvl: bus_wdata[B_OUT], dir_in: bus_wdata[B_DIR], use_gpio: bus_wdata[B_USE]};
    assign wr_sense = '{sense_off: bus_wdata[B_SOFF], pull: bus_wdata[1:0]};
    assign unused_wbits = ^{bus_wdata[30:3]};

    always_ff @(posedge clk) begin
        if (rst)                                irq_sel <= 1'b0;
        else if (bus_wr && sel.kind == RK_CTL)  irq_sel <= bus_wdata[0];
    end

    for (genvar g = 0; g < int'(NUM_PINS); g++) begin : g_pin
        logic wr1, wr2;
        assign wr1 = bus_wr && sel.kind == RK_CFG1 && sel.idx == IDX_W'(g);
        assign wr2 = bus_wr && sel.kind == RK_CFG2 && sel.idx == IDX_W'(g);

        gpio_pin_cell #(.SYNC_STAGES(2)) u_cell (
            .clk         (clk),
            .rst         (rst),
            .wr_pad_en   (wr1),
            .wr_sense_en (wr2),
            .pad_nxt     (wr_pad),
            .sense_nxt   (wr_sense),
            .pad_i       (pad_in[g]),
            .pad_q       (pad_q[g]),
            .sense_q     (sense_q[g]),
            .level_o     (pin_level[g])
        );

        assign pad_out[g]       = pad_q[g].out_lvl;
        assign pad_oe[g]        = pad_q[g].use_gpio & ~pad_q[g].dir_in;
        assign pad_pull[2*g +: 2] = sense_q[g].pull;
    end

    gpio_bank_rdmux #(.NUM_PINS(NUM_PINS), .WORDS(WORDS)) u_rdmux (
        .sel       (sel),
        .own_words (own_words),
        .pad_q     (pad_q),
        .sense_q   (sense_q),
        .level     (pin_level),
        .irq_sel   (irq_sel),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int unsigned NUM_PINS = 95,
    parameter int unsigned ADDR_W   = 10
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic [31:0]           bus_wdata,
    input logic [NUM_PINS-1:0]   pad_in,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [2*NUM_PINS-1:0] pad_pull,
    input logic [NUM_PINS-1:0]   pin_level,
    input logic                  irq_sel
);

    logic wr_p0_c1, wr_p0_c2, wr_ctl;
    assign wr_p0_c1 = bus_wr && (bus_addr & ~ADDR_W'(3)) == ADDR_W'(12'h100);
    assign wr_p0_c2 = bus_wr && (bus_addr & ~ADDR_W'(3)) == ADDR_W'(12'h104);
    assign wr_ctl   = bus_wr && (bus_addr & ~ADDR_W'(3)) == ADDR_W'(12'h07C);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pin_level == '0 && !irq_sel));

    a_r3_out_follows: assert property (@(posedge clk) disable iff (rst)
        wr_p0_c1 |=> pad_out[0] == $past(bus_wdata[31]));

    a_r4_oe_polarity: assert property (@(posedge clk) disable iff (rst)
        wr_p0_c1 |=> pad_oe[0] == ($past(bus_wdata[0]) && !$past(bus_wdata[2])));

    a_r5_pull_out: assert property (@(posedge clk) disable iff (rst)
        wr_p0_c2 |=> pad_pull[1:0] == $past(bus_wdata[1:0]));

    a_r6_two_stage: assert property (@(posedge clk) disable iff (rst)
        pin_level[0] |-> $past(pad_in[0], 2));

    a_r7_sense_gate: assert property (@(posedge clk) disable iff (rst)
        (wr_p0_c2 && bus_wdata[2]) |=> !pin_level[0]);

    a_r8_line_sel: assert property (@(posedge clk) disable iff (rst)
        wr_ctl |=> irq_sel == $past(bus_wdata[0]));

endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pull  (pad_pull),
    .pin_level (pin_level),
    .irq_sel   (irq_sel)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;

    localparam int NP = 95;
    localparam int AW = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   owner_strap;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out, pad_oe, pin_level;
    logic [2*NP-1:0] pad_pull;
    logic            irq_sel;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .owner_strap(owner_strap),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .pin_level(pin_level), .irq_sel(irq_sel)
    );

    function automatic logic strap_b(int i); return ((i * 7) % 5) != 0; endfunction
    function automatic logic p_out(int i);   return (i % 2) == 1;        endfunction
    function automatic logic p_dir(int i);   return ((i / 2) % 2) == 1;  endfunction
    function automatic logic p_use(int i);   return ((i / 4) % 2) == 1;  endfunction
    function automatic logic p_dis(int i);   return (i % 3) == 0;        endfunction
    function automatic logic [1:0] p_pull(int i); return 2'(i % 4);      endfunction
    function automatic logic p_in(int i);    return ((i * 5 + 1) % 4) < 2; endfunction

    function automatic logic [AW-1:0] a_c1(int i); return AW'(256 + 8 * i); endfunction
    function automatic logic [AW-1:0] a_c2(int i); return AW'(260 + 8 * i); endfunction

    task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_c1(int i, logic lvl);
        return {p_out(i), lvl, 27'b0, p_dir(i), 1'b0, p_use(i)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0]   d;
        logic [NP-1:0] v_out, v_oe, v_lvl;
        logic [2*NP-1:0] v_pull;

        for (int i = 0; i < NP; i++) owner_strap[i] = strap_b(i);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < NP; i++) begin
            rd(a_c1(i), d); chk($sformatf("R1 cfg1 pin%0d", i), 256'(d), 256'(32'h5));
            rd(a_c2(i), d); chk($sformatf("R1 cfg2 pin%0d", i), 256'(d), 256'(32'h4));
        end
        chk("R1 pad_oe", 256'(pad_oe), 256'(0));
        chk("R1 pad_out", 256'(pad_out), 256'(0));
        chk("R1 pad_pull", 256'(pad_pull), 256'(0));
        chk("R1 pin_level", 256'(pin_level), 256'(0));
        chk("R1 irq_sel", 256'(irq_sel), 256'(0));

        // R2: ownership words, read-only
        for (int w = 0; w < 3; w++) begin
            logic [31:0] e;
            for (int b = 0; b < 32; b++) e[b] = (w * 32 + b < NP) ? strap_b(w * 32 + b) : 1'b0;
            wr(AW'(4 * w), ~e);
            rd(AW'(4 * w), d);
            chk($sformatf("R2 own word%0d", w), 256'(d), 256'(e));
        end

        // R3, R4: first config word on every pin, with junk bits set
        for (int i = 0; i < NP; i++)
            wr(a_c1(i), 32'h4000_0FF2 | {p_out(i), 28'b0, p_dir(i), 1'b0, p_use(i)});
        for (int i = 0; i < NP; i++) begin
            rd(a_c1(i), d);
            chk($sformatf("R3 cfg1 pin%0d", i), 256'(d), 256'(exp_c1(i, 1'b0)));
            v_out[i] = p_out(i);
            v_oe[i]  = p_use(i) & ~p_dir(i);
        end
        chk("R3 pad_out vector", 256'(pad_out), 256'(v_out));
        chk("R4 pad_oe vector", 256'(pad_oe), 256'(v_oe));

        // R5: second config word on every pin
        for (int i = 0; i < NP; i++)
            wr(a_c2(i), 32'hFFFF_FFF8 | {29'b0, p_dis(i), p_pull(i)});
        for (int i = 0; i < NP; i++) begin
            rd(a_c2(i), d);
            chk($sformatf("R5 cfg2 pin%0d", i), 256'(d), 256'({29'b0, p_dis(i), p_pull(i)}));
            v_pull[2*i +: 2] = p_pull(i);
        end
        chk("R5 pad_pull vector", 256'(pad_pull), 256'(v_pull));

        // R6: two-edge synchronizer latency
        for (int i = 0; i < NP; i++) v_lvl[i] = p_in(i) & ~p_dis(i);
        @(negedge clk);
        for (int i = 0; i < NP; i++) pad_in[i] = p_in(i);
        @(posedge clk); #1;
        chk("R6 level after one edge", 256'(pin_level), 256'(0));
        @(posedge clk); #1;
        chk("R6 level after two edges", 256'(pin_level), 256'(v_lvl));
        // R7: gated pins read 0 in bit 30
        for (int i = 0; i < NP; i++) begin
            rd(a_c1(i), d);
            chk($sformatf("R7 cfg1 level pin%0d", i), 256'(d), 256'(exp_c1(i, v_lvl[i])));
        end

        // R7: toggle sensing on pin 4 whose input is high
        wr(a_c2(4), 32'h4);
        chk("R7 sense off level", 256'(pin_level[4]), 256'(0));
        rd(a_c1(4), d);
        chk("R7 sense off bit30", 256'(d[30]), 256'(0));
        wr(a_c2(4), 32'h0);
        chk("R7 sense on level", 256'(pin_level[4]), 256'(1));
        // R10: neighbours untouched by the pin 4 writes
        chk("R10 other levels", 256'(pin_level), 256'(v_lvl));
        chk("R10 other pulls", 256'(pad_pull), 256'(v_pull & ~(190'(3) << 8)));

        // R8: interrupt line select
        wr(AW'(12'h07C), 32'h0000_0001);
        chk("R8 irq_sel high", 256'(irq_sel), 256'(1));
        rd(AW'(12'h07C), d);
        chk("R8 ctl readback", 256'(d), 256'(1));
        wr(AW'(12'h07C), 32'hFFFF_FFFE);
        chk("R8 irq_sel low", 256'(irq_sel), 256'(0));
        rd(AW'(12'h07C), d);
        chk("R8 ctl readback zero", 256'(d), 256'(0));

        // R9: unmapped addresses
        begin
            logic [AW-1:0] holes [5] = '{AW'(12'h00C), AW'(12'h080), AW'(12'h0F8),
                                        AW'(12'h3F8), AW'(12'h3FC)};
            for (int k = 0; k < 5; k++) begin
                wr(holes[k], 32'hFFFF_FFFF);
                rd(holes[k], d);
                chk($sformatf("R9 hole %0h", holes[k]), 256'(d), 256'(0));
            end
        end
        rd(a_c1(94), d);
        chk("R9 pin94 cfg1 intact", 256'(d), 256'(exp_c1(94, v_lvl[94])));
        rd(a_c2(94), d);
        chk("R9 pin94 cfg2 intact", 256'(d), 256'({29'b0, p_dis(94), p_pull(94)}));
        chk("R9 pad_out intact", 256'(pad_out), 256'(v_out));
        chk("R9 irq_sel intact", 256'(irq_sel), 256'(0));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule